// File: doc/BRIEF.md
# Conversion Clock and Channel Sequencer

This block paces a four-channel acquisition front end. It picks one master period from a small fixed set, multiplies it by 1, 2, 4 or 8, and produces one rate tick per resulting period. On each tick it takes the next channel of the active scan, in ascending order, and wraps at the end of the scan. It then puts out that channel's tag, the sample word for that channel and a one-cycle sample-valid strobe. Sample words come from a 16-bit two's complement stimulus bus, with one lane per channel.

A 13-bit configuration word controls the block. It holds the scan code, the master clock select, the divisor shift, an enable for each channel pair and two power-down bits. While either power-down bit is set, the divider and the sequence are held. When power-down is released, the divider restarts from zero. A calibration-busy flag then stays high for a parameterized number of ticks, and no samples are issued until it clears. A channel whose pair is not enabled returns the grounded value zero in place of its input.

Top module: `conv_clock_sequencer`

## Requirements
- R1: During and after reset with power-down set, rateTick, sampleValid, sampleChan and sampleData are zero and calBusy is one.
- R2: A scan code of the form 1xx in cfgWord[2:0] samples only channel xx, so every sample-valid carries tag xx.
- R3: Scan code 010 samples channels 0 then 1 and repeats. Scan code 011 samples channels 2 then 3 and repeats.
- R4: Scan code 001 samples channels 0, 1, 2, 3 and repeats. Scan code 000 issues no sample-valid while ticks continue.
- R5: The tick period in clock cycles is floor(master_ns / CLK_NS) shifted left by cfgWord[6:5]. The master is chosen by cfgWord[4:3]. The four-clock variant (VARIANT 0) has masters 31250, 22676, 20833 and 19531 ns, and the three-clock variant (VARIANT 1) has 62500, 50000 and 41667 ns. A sample-valid only appears together with rateTick.
- R6: In the three-clock variant, select value 3 uses master 0.
- R7: cfgWord[7] enables channels 0 and 1, and cfgWord[8] enables channels 2 and 3. A sample from an enabled channel is that channel's 16-bit lane of sampleIn, unchanged. A sample from a disabled pair is 16'h0000.
- R8: While cfgWord[11] or cfgWord[12] is set, no tick and no sample occur. After both are released, the first tick comes exactly one full period later.
- R9: calBusy is set while power-down is active. After release it stays high for CAL_TICKS ticks, with no sample-valid, and clears on the last of them. The first sample after that is the first channel of the scan.
- R10: cfgWord[10:9] have no effect on period, tags or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWord | input | 13 | Configuration: scan code, clock select, shift, pair enables, reserved, power-downs |
| sampleIn | input | 4*DATA_W | Per-channel sample lanes, channel 0 in the lowest lane |
| rateTick | output | 1 | One-cycle pulse per conversion period |
| sampleValid | output | 1 | One-cycle strobe for an issued sample |
| sampleChan | output | 2 | Channel tag of the last issued sample |
| sampleData | output | DATA_W | Data of the last issued sample |
| calBusy | output | 1 | Calibration interval in progress |

## Verification
The assertions assume that CAL_TICKS is at least one. They also assume that the clock select and shift change only while power-down is asserted, or to a period that still exceeds one cycle. The tick-spacing and scan-range properties rely on this. The stimulus keeps to these limits: every new scan code, clock select and shift is applied under power-down and then released, and the clock period parameter is set so that every master period spans tens of cycles. Both variants are instantiated so that the fallback for an unpopulated select is exercised.

// File: rtl/convseq_pkg.sv
package convseq_pkg;

  localparam int NUM_CH = 4;
  localparam int CH_W   = 2;
  localparam int CFG_W  = 13;

  // MSB first: 12 digital power-down, 11 analog power-down, 10:9 reserved,
  // 8:7 pair enables, 6:5 divisor shift, 4:3 clock select, 2:0 scan code
  typedef struct packed {
    logic       digPd;
    logic       anaPd;
    logic [1:0] reserved;
    logic [1:0] pairEn;
    logic [1:0] divShift;
    logic [1:0] clkSel;
    logic [2:0] scanMode;
  } cfg_t;

  typedef struct packed {
    logic            tick;
    logic            emit;
    logic [CH_W-1:0] chan;
  } strobe_t;

  function automatic int numClocks(input int variant);
    return (variant == 0) ? 4 : 3;
  endfunction

  function automatic int masterNs(input int variant, input int idx);
    int ns;
    if (variant == 0) begin
      case (idx)
        0: ns = 31250;
        1: ns = 22676;
        2: ns = 20833;
        default: ns = 19531;
      endcase
    end else begin
      case (idx)
        0: ns = 62500;
        1: ns = 50000;
        default: ns = 41667;
      endcase
    end
    return ns;
  endfunction

  function automatic int masterCycles(input int variant, input int idx, input int clkNs);
    int n;
    n = masterNs(variant, idx) / clkNs;
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/convseq_rate_div.sv
module convseq_rate_div
  import convseq_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int CLK_NS  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hold,
  input  logic [1:0] clkSel,
  input  logic [1:0] divShift,
  output logic       tick
);

  localparam int NCLK    = numClocks(VARIANT);
  localparam int MAX_CYC = masterCycles(VARIANT, 0, CLK_NS) * 8;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] baseCyc [4];
  logic [CNT_W-1:0] periodCyc;
  logic [CNT_W-1:0] cnt;

  // Unpopulated selects fall back to master 0
  for (genvar g = 0; g < 4; g++) begin : gBase
    localparam int IDX = (g < NCLK) ? g : 0;
    assign baseCyc[g] = CNT_W'(masterCycles(VARIANT, IDX, CLK_NS));
  end

  assign periodCyc = baseCyc[clkSel] << divShift;
  assign tick      = !hold && (cnt >= periodCyc - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (hold || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && periodCyc > 1) |=> (!tick || periodCyc == 1)); // R5

endmodule

// File: rtl/convseq_scan_ctrl.sv
module convseq_scan_ctrl
  import convseq_pkg::*;
#(
  parameter int CAL_TICKS = 36
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] scanMode,
  input  logic       anaPd,
  input  logic       digPd,
  input  logic       tick,
  output logic       pwrDown,
  output logic       calBusy,
  output strobe_t    strobe
);

  localparam int CAL_W = (CAL_TICKS < 2) ? 1 : $clog2(CAL_TICKS + 1);
  localparam logic [CAL_W-1:0] CAL_LAST = CAL_W'(CAL_TICKS - 1);

  logic            scanActive;
  logic [CH_W-1:0] scanBase;
  logic [CH_W-1:0] scanLastPos;
  logic [CH_W-1:0] pos;
  logic [CH_W-1:0] posEff;
  logic [CAL_W-1:0] calCnt;

  assign pwrDown = anaPd | digPd;

  always_comb begin
    scanActive  = 1'b1;
    scanBase    = '0;
    scanLastPos = '0;
    casez (scanMode)
      3'b1??: begin scanBase = scanMode[1:0]; scanLastPos = 2'd0; end
      3'b010: begin scanBase = 2'd0;          scanLastPos = 2'd1; end
      3'b011: begin scanBase = 2'd2;          scanLastPos = 2'd1; end
      3'b001: begin scanBase = 2'd0;          scanLastPos = 2'd3; end
      default: scanActive = 1'b0;
    endcase
  end

  assign posEff = (pos > scanLastPos) ? '0 : pos;

  assign strobe.tick = tick;
  assign strobe.emit = tick && scanActive && !calBusy && !pwrDown;
  assign strobe.chan = scanBase + posEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos     <= '0;
      calBusy <= 1'b1;
      calCnt  <= '0;
    end else if (pwrDown) begin
      pos     <= '0;
      calBusy <= 1'b1;
      calCnt  <= '0;
    end else if (tick) begin
      if (calBusy) begin
        calCnt <= calCnt + 1'b1;
        if (calCnt == CAL_LAST) calBusy <= 1'b0;
      end else if (scanActive) begin
        pos <= (posEff == scanLastPos) ? '0 : posEff + 1'b1;
      end
    end
  end

  AST_SINGLE_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && scanMode[2]) |-> (strobe.chan == scanMode[1:0])); // R2

  AST_PAIR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && scanMode[2:1] == 2'b01) |-> (strobe.chan[1] == scanMode[0])); // R3

  AST_PD_RELOADS_CAL: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> calBusy); // R9

endmodule

// File: rtl/convseq_sample_path.sv
module convseq_sample_path
  import convseq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobe,
  input  logic [1:0]               pairEn,
  input  logic [NUM_CH*DATA_W-1:0] sampleIn,
  output logic                     rateTick,
  output logic                     sampleValid,
  output logic [CH_W-1:0]          sampleChan,
  output logic [DATA_W-1:0]        sampleData
);

  logic [DATA_W-1:0] chanWord [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : gLane
    assign chanWord[c] = pairEn[c/2] ? sampleIn[c*DATA_W +: DATA_W] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateTick    <= 1'b0;
      sampleValid <= 1'b0;
      sampleChan  <= '0;
      sampleData  <= '0;
    end else begin
      rateTick    <= strobe.tick;
      sampleValid <= strobe.emit;
      if (strobe.emit) begin
        sampleChan <= strobe.chan;
        sampleData <= chanWord[strobe.chan];
      end
    end
  end

  AST_VALID_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> rateTick); // R5

  AST_GROUNDED_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && !pairEn[strobe.chan[1]]) |=> (sampleData == '0)); // R7

endmodule

// File: rtl/conv_clock_sequencer.sv
module conv_clock_sequencer
  import convseq_pkg::*;
#(
  parameter int VARIANT   = 0,
  parameter int CLK_NS    = 10,
  parameter int CAL_TICKS = 36,
  parameter int DATA_W    = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CFG_W-1:0]         cfgWord,
  input  logic [NUM_CH*DATA_W-1:0] sampleIn,
  output logic                     rateTick,
  output logic                     sampleValid,
  output logic [CH_W-1:0]          sampleChan,
  output logic [DATA_W-1:0]        sampleData,
  output logic                     calBusy
);

  cfg_t    cfg;
  strobe_t strobe;
  logic    tick;
  logic    pwrDown;
  logic    unusedReserved;

  assign cfg            = cfg_t'(cfgWord);
  assign unusedReserved = ^cfg.reserved;

  convseq_rate_div #(.VARIANT(VARIANT), .CLK_NS(CLK_NS)) uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .hold     (pwrDown),
    .clkSel   (cfg.clkSel),
    .divShift (cfg.divShift),
    .tick     (tick)
  );

  convseq_scan_ctrl #(.CAL_TICKS(CAL_TICKS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .scanMode (cfg.scanMode),
    .anaPd    (cfg.anaPd),
    .digPd    (cfg.digPd),
    .tick     (tick),
    .pwrDown  (pwrDown),
    .calBusy  (calBusy),
    .strobe   (strobe)
  );

  convseq_sample_path #(.DATA_W(DATA_W)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .pairEn      (cfg.pairEn),
    .sampleIn    (sampleIn),
    .rateTick    (rateTick),
    .sampleValid (sampleValid),
    .sampleChan  (sampleChan),
    .sampleData  (sampleData)
  );

  AST_NO_VALID_IN_PD: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> !sampleValid); // R8

  AST_NO_VALID_WHILE_CAL: assert property (@(posedge clk) disable iff (!rstN)
    calBusy |=> !sampleValid); // R9

endmodule

// File: tb/tb_conv_clock_sequencer.sv
module tb_conv_clock_sequencer;

  localparam int CLK_NS_P = 1000;
  localparam int CAL_P    = 3;
  localparam logic [12:0] PD_BOTH = 13'h1800;

  typedef struct packed {
    logic [12:0] cfg;
    logic [15:0] period;
    logic [7:0]  seq;
    logic        hasSamples;
  } vec_t;

  // cfg, expected tick period, expected tags (tag k at bits 2k+1:2k), samples issued
  localparam vec_t VECS [7] = '{
    '{13'h185, 16'd31,  8'h55, 1'b1},  // R2 ch1, sel0 shift0
    '{13'h1AA, 16'd44,  8'h44, 1'b1},  // R3 pair 0/1, sel1 shift1
    '{13'h7D3, 16'd80,  8'hEE, 1'b1},  // R3 pair 2/3, sel2 shift2, R10 reserved set
    '{13'h1F9, 16'd152, 8'hE4, 1'b1},  // R4 all four, sel3 shift3
    '{13'h099, 16'd19,  8'hE4, 1'b1},  // R7 upper pair grounded
    '{13'h0A6, 16'd62,  8'hAA, 1'b1},  // R7 ch2 grounded
    '{13'h188, 16'd22,  8'h00, 1'b0}   // R4 code 000
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic [12:0] cfgWord, cfgWordS;
  logic [63:0] sampleIn;
  logic        rateTick, sampleValid, calBusy;
  logic [1:0]  sampleChan;
  logic [15:0] sampleData;
  logic        rateTickS, sampleValidS, calBusyS;
  logic [1:0]  sampleChanS;
  logic [15:0] sampleDataS;

  int nChecks = 0;
  int nFails  = 0;

  conv_clock_sequencer #(.VARIANT(0), .CLK_NS(CLK_NS_P), .CAL_TICKS(CAL_P)) dut (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .sampleIn(sampleIn),
    .rateTick(rateTick), .sampleValid(sampleValid), .sampleChan(sampleChan),
    .sampleData(sampleData), .calBusy(calBusy)
  );

  conv_clock_sequencer #(.VARIANT(1), .CLK_NS(CLK_NS_P), .CAL_TICKS(CAL_P)) dutS (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWordS), .sampleIn(sampleIn),
    .rateTick(rateTickS), .sampleValid(sampleValidS), .sampleChan(sampleChanS),
    .sampleData(sampleDataS), .calBusy(calBusyS)
  );

  function automatic logic [15:0] laneVal(input int c);
    case (c)
      0: return 16'h8001;
      1: return 16'h7FFE;
      2: return 16'hFFFF;
      default: return 16'h0005;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitTick(output int cycles);
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!rateTick && cycles < 2000);
  endtask

  task automatic waitTickS(output int cycles);
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!rateTickS && cycles < 2000);
  endtask

  task automatic runVec(input vec_t v);
    int cyc;
    logic [1:0] expChan;
    logic [15:0] expData;
    string req;
    req = v.cfg[2] ? "R2" : ((v.cfg[2:0] == 3'b001) ? "R4" : "R3");
    cfgWord = v.cfg | PD_BOTH;
    repeat (3) @(negedge clk);
    check(!rateTick && calBusy, "R8", "held in power-down", {rateTick, calBusy}, 1);
    cfgWord = v.cfg;
    waitTick(cyc);
    check(cyc == int'(v.period), "R8", "first tick after release", cyc, v.period);
    for (int k = 1; k <= CAL_P + 4; k++) begin
      if (k > 1) begin
        waitTick(cyc);
        check(cyc == int'(v.period), "R5", "tick period", cyc, v.period);
      end
      if (k <= CAL_P) begin
        check(!sampleValid, "R9", "no sample while calibrating", sampleValid, 0);
        check(calBusy == (k < CAL_P), "R9", "calBusy during interval", calBusy, k < CAL_P);
      end else if (!v.hasSamples) begin
        check(!sampleValid, "R4", "code 000 issues nothing", sampleValid, 0);
      end else begin
        expChan = v.seq[2*(k-CAL_P-1) +: 2];
        check(sampleValid && sampleChan == expChan, req, "sample tag", sampleChan, expChan);
        expData = (expChan < 2 ? v.cfg[7] : v.cfg[8]) ? laneVal(int'(expChan)) : 16'h0000;
        check(sampleData == expData, "R7", "sample data", sampleData, expData);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int cyc;
    int ticks;
    rstN     = 1'b0;
    cfgWord  = PD_BOTH;
    cfgWordS = PD_BOTH;
    sampleIn = {laneVal(3), laneVal(2), laneVal(1), laneVal(0)};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!rateTick && !sampleValid && sampleChan == 0 && sampleData == 0 && calBusy,
          "R1", "outputs in reset", sampleData, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!rateTick && !sampleValid && calBusy, "R1", "after reset in power-down", calBusy, 1);

    foreach (VECS[i]) runVec(VECS[i]);

    // R8: analog power-down alone stops ticks
    cfgWord = 13'h185 | 13'h0800;
    ticks = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (rateTick || sampleValid) ticks++;
    end
    check(ticks == 0, "R8", "no ticks under analog power-down", ticks, 0);
    check(calBusy, "R9", "calBusy under power-down", calBusy, 1);
    // R8: digital power-down alone
    cfgWord = 13'h185 | 13'h1000;
    ticks = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (rateTick || sampleValid) ticks++;
    end
    check(ticks == 0, "R8", "no ticks under digital power-down", ticks, 0);
    cfgWord = 13'h185;
    waitTick(cyc);
    check(cyc == 31, "R8", "restart after digital power-down", cyc, 31);

    // R6: three-clock variant, select 3 falls back to master 0
    cfgWordS = 13'h199;
    waitTickS(cyc);
    check(cyc == 62, "R6", "select 3 uses master 0", cyc, 62);
    cfgWordS = 13'h191 | PD_BOTH;
    repeat (2) @(negedge clk);
    cfgWordS = 13'h191;
    waitTickS(cyc);
    check(cyc == 41, "R5", "three-clock master 2", cyc, 41);
    cfgWordS = 13'h1A9 | PD_BOTH;
    repeat (2) @(negedge clk);
    cfgWordS = 13'h1A9;
    waitTickS(cyc);
    check(cyc == 100, "R5", "three-clock master 1 shift 1", cyc, 100);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule